// File: doc/BRIEF.md
# UART Interrupt Request Generator

This block raises the three interrupt requests of a UART: transmit, receive and modem status. The UART can run in character mode, with a single holding register in each direction, or in queued mode, with a FIFO in each direction. A control input selects the mode. The block does not contain the serializer, the deserializer or the FIFO storage. Instead, it observes the fill level of each queue, the valid flags of the holding registers, strobes for character arrival and for host reads, and a tick that marks each bit period.

In queued mode, the transmit request asks for refill when half the queue or more is free. The receive request asks for service when half the queue or more is occupied. The receive request also fires when a non-empty queue has been idle for three character times. That idle indication persists until the host has drained the queue. The modem-status request is a sticky flag. It is set when either the clear-to-send or the data-set-ready line changes level after synchronization, and it is cleared by an acknowledge strobe.

Top module: `uart_irq_gen`

## Requirements
- R1: With `fifo_en` = 0, `tx_irq` is 1 exactly when `tx_hold_full` was 0 one cycle earlier; `tx_level` has no effect.
- R2: With `fifo_en` = 1, `tx_irq` is 1 exactly when `tx_level` was at most DEPTH/2 (8 for the default 16) one cycle earlier; `tx_hold_full` has no effect.
- R3: With `fifo_en` = 0, `rx_irq` equals `rx_hold_valid` of the previous cycle; `rx_level` and idle time have no effect.
- R4: With `fifo_en` = 1, `rx_irq` is 1 one cycle after `rx_level` is at least DEPTH/2; `rx_hold_valid` has no effect.
- R5: With `fifo_en` = 1 and `rx_level` non-zero, 30 `bit_tick` pulses (3 characters of 10 bits) without a receive or read strobe raise `rx_irq`. The request is seen one cycle after the clock edge that samples the 30th tick. After 29 ticks, `rx_irq` stays 0.
- R6: A pulse on `rx_char_stb` or `rx_read_stb` restarts the idle count from zero.
- R7: Once the idle condition is raised, it stays raised across new characters and reads. It is cleared only by `rx_level` = 0, after which `rx_irq` is 0 one cycle later.
- R8: A level change on `cts_in` or `dsr_in` sets `ms_irq`. The flag is visible three clock edges after the input change, and not at two.
- R9: `ms_irq` stays set until a one-cycle `ms_eoi` pulse clears it. A change detected in the same cycle as `ms_eoi` wins, and the flag remains set.
- R10: During reset, all three outputs are 0. Modem lines held constant through reset raise no `ms_irq` afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 = queued mode, 0 = character mode |
| tx_level | input | LVL_W (5) | Entries in the transmit queue |
| tx_hold_full | input | 1 | Transmit holding register occupied |
| rx_level | input | LVL_W (5) | Entries in the receive queue |
| rx_hold_valid | input | 1 | Receive holding register has valid data |
| rx_char_stb | input | 1 | One-cycle pulse per received character |
| rx_read_stb | input | 1 | One-cycle pulse per host read of receive data |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| cts_in | input | 1 | Asynchronous clear-to-send line |
| dsr_in | input | 1 | Asynchronous data-set-ready line |
| ms_eoi | input | 1 | Acknowledge pulse for the modem-status request |
| tx_irq | output | 1 | Transmit request |
| rx_irq | output | 1 | Receive request |
| ms_irq | output | 1 | Modem-status request |

## Verification
The occupancy requests are registered once. The bench therefore changes levels and flags at a falling edge and samples one falling edge later. The idle timeout adds one more register: the flag is set on the edge that samples the 30th tick, and `rx_irq` follows on the next edge. The bench checks low after 29 ticks plus a margin, and high one falling edge after the 30th. A modem line passes two synchronizer stages and then the sticky flag. Its checks sample low two falling edges after the change and high at the third. The acknowledge collision is placed in the exact cycle in which the change is detected.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
   // Modem-status line pair, kept together through synchronization
   typedef struct packed {
      logic cts;
      logic dsr;
   } uirq_ms_t;

   localparam int unsigned UIRQ_MS_W = $bits(uirq_ms_t);
endpackage

// File: rtl/uirq_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous lines.
module uirq_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("uirq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d_async;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   endgenerate

   assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/uirq_rx_idle.sv
// Counts bit periods of receive inactivity while the queue holds data.
module uirq_rx_idle #(
   parameter int unsigned LIMIT = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fifo_en,
   input  logic rx_nonempty,
   input  logic rx_char_stb,
   input  logic rx_read_stb,
   input  logic bit_tick,
   output logic idle_flag
);
   localparam int unsigned CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("uirq_rx_idle: LIMIT must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         idle_flag <= 1'b0;
      end else if (!fifo_en || !rx_nonempty) begin
         cnt       <= '0;
         idle_flag <= 1'b0;
      end else if (rx_char_stb || rx_read_stb) begin
         cnt       <= '0;
      end else if (bit_tick && !idle_flag) begin
         if (cnt == LAST) begin
            cnt       <= '0;
            idle_flag <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/uirq_occ.sv
// Registered occupancy-based transmit and receive requests.
module uirq_occ #(
   parameter int unsigned LVL_W = 5,
   parameter int unsigned HALF  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic [LVL_W-1:0] tx_level,
   input  logic             tx_hold_full,
   input  logic [LVL_W-1:0] rx_level,
   input  logic             rx_hold_valid,
   input  logic             idle_flag,
   output logic             tx_irq,
   output logic             rx_irq
);
   localparam logic [LVL_W-1:0] HALF_L = LVL_W'(HALF);

   logic tx_next, rx_next;

   always_comb begin
      if (fifo_en) begin
         tx_next = (tx_level <= HALF_L);
         rx_next = (rx_level >= HALF_L) || (idle_flag && (rx_level != '0));
      end else begin
         tx_next = !tx_hold_full;
         rx_next = rx_hold_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_irq <= 1'b0;
         rx_irq <= 1'b0;
      end else begin
         tx_irq <= tx_next;
         rx_irq <= rx_next;
      end
   end
endmodule

// File: rtl/uirq_msr.sv
// Sticky modem-status change flag with acknowledge.
module uirq_msr
   import uirq_pkg::*;
#(
   parameter int unsigned WARM = 3
) (
   input  logic     clk,
   input  logic     rst_n,
   input  uirq_ms_t lines,
   input  logic     ack,
   output logic     flag
);
   uirq_ms_t   prev;
   logic [WARM-1:0] warm;
   logic       change;

   // Detection is held off until the synchronizer has carried real samples
   assign change = warm[WARM-1] && (lines != prev);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev <= '0;
         warm <= '0;
         flag <= 1'b0;
      end else begin
         prev <= lines;
         warm <= {warm[WARM-2:0], 1'b1};
         if (change)   flag <= 1'b1;
         else if (ack) flag <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
   import uirq_pkg::*;
#(
   parameter int unsigned DEPTH         = 16,
   parameter int unsigned BITS_PER_CHAR = 10,
   parameter int unsigned IDLE_CHARS    = 3,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned LVL_W         = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic [LVL_W-1:0] tx_level,
   input  logic             tx_hold_full,
   input  logic [LVL_W-1:0] rx_level,
   input  logic             rx_hold_valid,
   input  logic             rx_char_stb,
   input  logic             rx_read_stb,
   input  logic             bit_tick,
   input  logic             cts_in,
   input  logic             dsr_in,
   input  logic             ms_eoi,
   output logic             tx_irq,
   output logic             rx_irq,
   output logic             ms_irq
);
   localparam int unsigned HALF       = DEPTH / 2;
   localparam int unsigned IDLE_TICKS = BITS_PER_CHAR * IDLE_CHARS;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("uart_irq_gen: DEPTH must be a power of two, at least 2");
      end
      if (LVL_W < $clog2(DEPTH + 1)) begin : g_bad_lvl
         $error("uart_irq_gen: LVL_W too narrow for DEPTH");
      end
      if (IDLE_TICKS < 1) begin : g_bad_idle
         $error("uart_irq_gen: idle window must be non-zero");
      end
   endgenerate

   uirq_ms_t ms_raw, ms_sync;
   logic     idle_flag;

   assign ms_raw.cts = cts_in;
   assign ms_raw.dsr = dsr_in;

   uirq_sync #(.WIDTH(UIRQ_MS_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (ms_raw),
      .q_sync  (ms_sync)
   );

   uirq_msr #(.WARM(SYNC_STAGES + 1)) u_msr (
      .clk   (clk),
      .rst_n (rst_n),
      .lines (ms_sync),
      .ack   (ms_eoi),
      .flag  (ms_irq)
   );

   uirq_rx_idle #(.LIMIT(IDLE_TICKS)) u_idle (
      .clk         (clk),
      .rst_n       (rst_n),
      .fifo_en     (fifo_en),
      .rx_nonempty (rx_level != '0),
      .rx_char_stb (rx_char_stb),
      .rx_read_stb (rx_read_stb),
      .bit_tick    (bit_tick),
      .idle_flag   (idle_flag)
   );

   uirq_occ #(.LVL_W(LVL_W), .HALF(HALF)) u_occ (
      .clk           (clk),
      .rst_n         (rst_n),
      .fifo_en       (fifo_en),
      .tx_level      (tx_level),
      .tx_hold_full  (tx_hold_full),
      .rx_level      (rx_level),
      .rx_hold_valid (rx_hold_valid),
      .idle_flag     (idle_flag),
      .tx_irq        (tx_irq),
      .rx_irq        (rx_irq)
   );
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk #(
   parameter int unsigned LVL_W = 5,
   parameter int unsigned HALF  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fifo_en,
   input logic [LVL_W-1:0] tx_level,
   input logic             tx_hold_full,
   input logic [LVL_W-1:0] rx_level,
   input logic             rx_hold_valid,
   input logic             ms_eoi,
   input logic             tx_irq,
   input logic             rx_irq,
   input logic             ms_irq
);
   localparam logic [LVL_W-1:0] HALF_L = LVL_W'(HALF);

   a_r1_tx_hold_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && !tx_hold_full) |=> tx_irq);

   a_r2_tx_fifo_full: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && (tx_level > HALF_L)) |=> !tx_irq);

   a_r3_rx_hold_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |=> (rx_irq == $past(rx_hold_valid)));

   a_r4_rx_half_full: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && (rx_level >= HALF_L)) |=> rx_irq);

   a_r7_empty_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && (rx_level == '0)) |=> !rx_irq);

   a_r9_ms_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ms_irq && !ms_eoi) |=> ms_irq);
endmodule

bind uart_irq_gen uirq_chk #(.LVL_W(LVL_W), .HALF(DEPTH / 2)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .fifo_en       (fifo_en),
   .tx_level      (tx_level),
   .tx_hold_full  (tx_hold_full),
   .rx_level      (rx_level),
   .rx_hold_valid (rx_hold_valid),
   .ms_eoi        (ms_eoi),
   .tx_irq        (tx_irq),
   .rx_irq        (rx_irq),
   .ms_irq        (ms_irq)
);

// File: tb/sim_uart_irq_gen.sv
module sim_uart_irq_gen;
   localparam int unsigned LVL_W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fifo_en = 1'b0;
   logic [LVL_W-1:0] tx_level = '0;
   logic tx_hold_full = 1'b0;
   logic [LVL_W-1:0] rx_level = '0;
   logic rx_hold_valid = 1'b0;
   logic rx_char_stb = 1'b0;
   logic rx_read_stb = 1'b0;
   logic bit_tick = 1'b0;
   logic cts_in = 1'b1;
   logic dsr_in = 1'b0;
   logic ms_eoi = 1'b0;
   logic tx_irq, rx_irq, ms_irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   uart_irq_gen u0 (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
      .tx_level(tx_level), .tx_hold_full(tx_hold_full),
      .rx_level(rx_level), .rx_hold_valid(rx_hold_valid),
      .rx_char_stb(rx_char_stb), .rx_read_stb(rx_read_stb),
      .bit_tick(bit_tick), .cts_in(cts_in), .dsr_in(dsr_in),
      .ms_eoi(ms_eoi), .tx_irq(tx_irq), .rx_irq(rx_irq), .ms_irq(ms_irq)
   );

   // {fifo_en, tx_level, tx_hold_full, rx_level, rx_hold_valid, exp_tx, exp_rx}
   localparam int NV = 11;
   localparam logic [14:0] VEC [NV] = '{
      {1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 1'b1, 1'b0},
      {1'b0, 5'd0,  1'b1, 5'd0,  1'b0, 1'b0, 1'b0},
      {1'b0, 5'd5,  1'b1, 5'd0,  1'b1, 1'b0, 1'b1},
      {1'b0, 5'd16, 1'b0, 5'd12, 1'b0, 1'b1, 1'b0},
      {1'b0, 5'd0,  1'b1, 5'd9,  1'b1, 1'b0, 1'b1},
      {1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b1, 1'b0},
      {1'b1, 5'd8,  1'b0, 5'd7,  1'b0, 1'b1, 1'b0},
      {1'b1, 5'd9,  1'b0, 5'd8,  1'b0, 1'b0, 1'b1},
      {1'b1, 5'd16, 1'b1, 5'd16, 1'b1, 1'b0, 1'b1},
      {1'b1, 5'd7,  1'b1, 5'd0,  1'b1, 1'b1, 1'b0},
      {1'b1, 5'd12, 1'b0, 5'd3,  1'b0, 1'b0, 1'b0}
   };

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b at cycle %0d", req, act, exp, cycles);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) bit_tick = 1'b1;
         @(negedge clk) bit_tick = 1'b0;
      end
   endtask

   task automatic pulse_char();
      @(negedge clk) rx_char_stb = 1'b1;
      @(negedge clk) rx_char_stb = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R10: reset state, with cts held high through reset
      wait_neg(4);
      check("R10 tx", tx_irq, 1'b0);
      check("R10 rx", rx_irq, 1'b0);
      check("R10 ms", ms_irq, 1'b0);
      rst_n = 1'b1;
      wait_neg(8);
      check("R10 no spurious ms", ms_irq, 1'b0);

      // Table walk: R1 R2 R3 R4
      for (int v = 0; v < NV; v++) begin
         fifo_en       = VEC[v][14];
         tx_level      = VEC[v][13:9];
         tx_hold_full  = VEC[v][8];
         rx_level      = VEC[v][7:3];
         rx_hold_valid = VEC[v][2];
         @(negedge clk);
         check(VEC[v][14] ? "R2 tx" : "R1 tx", tx_irq, VEC[v][1]);
         check(VEC[v][14] ? "R4 rx" : "R3 rx", rx_irq, VEC[v][0]);
      end

      // R3: idle time ignored in character mode
      fifo_en = 1'b0; rx_hold_valid = 1'b0; rx_level = 5'd3;
      ticks(40);
      wait_neg(2);
      check("R3 idle ignored", rx_irq, 1'b0);

      // R5: timeout after exactly 30 ticks
      fifo_en = 1'b1; rx_level = 5'd3; tx_level = 5'd12;
      pulse_char();
      ticks(29);
      wait_neg(3);
      check("R5 29 ticks", rx_irq, 1'b0);
      ticks(1);
      @(negedge clk);
      check("R5 30 ticks", rx_irq, 1'b1);

      // R7: persists through new character, clears on empty
      rx_level = 5'd4;
      pulse_char();
      ticks(2);
      check("R7 persists", rx_irq, 1'b1);
      rx_level = 5'd0;
      @(negedge clk);
      check("R7 empty clears", rx_irq, 1'b0);

      // R6: restart on read and on character
      rx_level = 5'd2;
      pulse_char();
      ticks(20);
      @(negedge clk) begin rx_read_stb = 1'b1; rx_level = 5'd1; end
      @(negedge clk) rx_read_stb = 1'b0;
      ticks(20);
      wait_neg(2);
      check("R6 read restart", rx_irq, 1'b0);
      pulse_char();
      ticks(29);
      wait_neg(2);
      check("R6 char restart", rx_irq, 1'b0);
      ticks(1);
      @(negedge clk);
      check("R6 expiry after restart", rx_irq, 1'b1);
      rx_level = 5'd0;
      @(negedge clk);

      // R8: cts change, latency three edges
      @(negedge clk) cts_in = 1'b0;
      wait_neg(2);
      check("R8 not yet", ms_irq, 1'b0);
      @(negedge clk);
      check("R8 cts set", ms_irq, 1'b1);

      // R9: acknowledge clears
      ms_eoi = 1'b1;
      @(negedge clk) ms_eoi = 1'b0;
      check("R9 eoi clears", ms_irq, 1'b0);
      wait_neg(4);
      check("R9 stays clear", ms_irq, 1'b0);

      // R8: dsr change
      dsr_in = 1'b1;
      wait_neg(3);
      check("R8 dsr set", ms_irq, 1'b1);
      ms_eoi = 1'b1;
      @(negedge clk) ms_eoi = 1'b0;
      check("R9 clear again", ms_irq, 1'b0);

      // R9: change detected in same cycle as eoi wins
      cts_in = 1'b1;
      wait_neg(2);
      ms_eoi = 1'b1;
      @(negedge clk) ms_eoi = 1'b0;
      check("R9 set beats eoi", ms_irq, 1'b1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule